// File: doc/BRIEF.md
# Interrupt-Driven SPI Host Controller

This block is the host end of a serial link to a sensor that asks for service by pulling an active-low interrupt line. It also accepts a wake line that brings the sensor out of sleep. The controller passes the interrupt through a two-flop synchronizer. When the interrupt is seen while the controller is idle, it opens a transfer at once. User logic can also start a transfer with a one-cycle request. If the interrupt is not already asserted at that point, the controller first raises the wake line and holds it until the sensor answers by asserting the interrupt. If no answer arrives within a programmable number of cycles, the controller drops the attempt and raises a sticky error flag.

A transfer pulls chip select low and waits a minimum setup time. It then exchanges a programmed number of bytes in full duplex and waits a minimum hold time before it releases chip select. The serial clock idles high. Data leaves on the falling edge and is captured on the rising edge, most significant bit first. The clock half period and the chip-select delays are derived at elaboration from the system clock frequency and are rounded up to whole cycles. Toward the user logic there is a byte-wide transmit handshake that can stall the link between bytes, a receive strobe for each byte, a busy level and a done pulse.

Top module: `spi_irq_host`

## Requirements
- R1: After reset, cs_n_o is 1, sck_o is 1, and wake_o, busy_o, done_o, err_o and tx_ready_o are all 0.
- R2: When the synchronized interrupt is asserted (irq_n_i low) in idle, a transfer starts without raising wake_o, and this takes priority over start_i.
- R3: A start_i pulse in idle with irq_n_i high raises wake_o. wake_o stays high until the synchronized interrupt is asserted, then falls in the same cycle that cs_n_o falls, and the transfer proceeds.
- R4: If the interrupt is not seen while waking, wake_o stays high for exactly timeout_i+1 clock cycles. After that err_o is set, busy_o falls and cs_n_o never goes low.
- R5: err_o stays set until the controller next leaves idle, for a transfer or for a wake, and then reads 0.
- R6: Bytes use clock mode 3. sck_o idles high, mosi_o changes on the falling edge and miso_i is sampled on the rising edge. Bit 7 goes first, and each byte is exchanged in both directions at once.
- R7: Each low phase of sck_o lasts exactly HALF clock cycles. HALF is the smallest whole number of cycles whose duration is at least half the period of SCK_MAX_HZ (17 at 100 MHz and 3 MHz).
- R8: The first falling edge of sck_o comes at least CS_SETUP_NS, rounded up to whole cycles (10 by default), after cs_n_o falls.
- R9: Before each byte tx_ready_o is high. While tx_valid_i stays low, cs_n_o stays low and sck_o stays high, and the byte is taken in the cycle both are high.
- R10: A transfer exchanges exactly len_i+1 bytes, with one rx_valid_o pulse per byte carrying the received byte. done_o pulses for one cycle in the first cycle cs_n_o is high again.
- R11: cs_n_o rises at least CS_HOLD_NS, rounded up to whole cycles (2 by default), after the last rising edge of sck_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_n_i | input | 1 | Sensor service request, active low, asynchronous |
| wake_o | output | 1 | Wake request to the sensor, active high |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data toward the sensor |
| miso_i | input | 1 | Serial data from the sensor |
| start_i | input | 1 | One-cycle request for a host-initiated transfer |
| len_i | input | LEN_W | Byte count minus one, captured when the frame opens |
| timeout_i | input | TO_W | Wake wait limit in cycles |
| tx_data_i | input | 8 | Next byte to send |
| tx_valid_i | input | 1 | tx_data_i is valid |
| tx_ready_o | output | 1 | Controller waits for the next byte |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| busy_o | output | 1 | Controller not idle |
| done_o | output | 1 | One-cycle pulse when a transfer closes |
| err_o | output | 1 | Sticky wake-timeout flag |

## Verification
The main function is driven in four ways, each of which separates a different path. The first is a transfer opened by the sensor's interrupt, which must show no wake. The second is a host request that wakes a sleeping sensor, which must show a bounded wake pulse. The third is a host request that gets no answer, where the wake length must equal timeout_i+1 and no frame may open. The fourth is a multi-byte frame whose transmit data is withheld between bytes, which shows that the link freezes with the clock high. The byte patterns 00, FF, 01, 80, 55 and AA, sent and received in both directions, separate bit-order faults, stuck lines and sampling on the wrong edge. The timing monitors measure every low clock phase and the chip-select setup and hold in cycles.

// File: rtl/spi_irq_host_pkg.sv
package spi_irq_host_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_CSSU,
    ST_LOAD,
    ST_SHIFT,
    ST_HOLD
  } host_st_t;

  function automatic int ceil_div(longint num, longint den);
    return int'((num + den - 1) / den);
  endfunction

  // cycles per clock half so that the half period is never shorter than 1/(2*f_max)
  function automatic int sck_half_cycles(longint clk_hz, longint sck_max_hz);
    int n;
    n = ceil_div(clk_hz, 2 * sck_max_hz);
    return (n < 1) ? 1 : n;
  endfunction

  // a delay in nanoseconds turned into whole clock cycles, rounded up
  function automatic int ns_to_cycles(longint ns, longint clk_hz);
    int n;
    n = ceil_div(ns * clk_hz, 64'd1_000_000_000);
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/spi_irq_sync.sv
module spi_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n_i,
  output logic asserted_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= async_n_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_n_i};
      end
    end
  endgenerate

  assign asserted_o = ~chain_q[STAGES-1];

endmodule

// File: rtl/spi_irq_cnt.sv
module spi_irq_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q_o <= '0;
    else if (clr_i)      q_o <= '0;
    else if (q_o != '1)  q_o <= q_o + 1'b1;
  end

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int HALF = 17,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [DW-1:0] tx_i,
  input  logic          miso_i,
  output logic          sck_o,
  output logic          mosi_o,
  output logic          active_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o,
  output logic          fall_ev_o,
  output logic          rise_ev_o
);

  localparam int DIV_W = $clog2(HALF + 1);
  localparam int BIT_W = $clog2(DW + 1);

  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;
  logic [DW-1:0]    sh_q;
  logic [DW-1:0]    rx_q;
  logic             sck_q;
  logic             mosi_q;
  logic             act_q;
  logic             done_q;
  logic             tick;
  logic             last_bit;

  assign tick      = act_q && (div_q == DIV_W'(HALF - 1));
  assign fall_ev_o = tick && sck_q;
  assign rise_ev_o = tick && !sck_q;
  assign last_bit  = (bit_q == BIT_W'(DW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      sck_q  <= 1'b1;
      mosi_q <= 1'b0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (go_i) begin
          act_q <= 1'b1;
          sh_q  <= tx_i;
          bit_q <= '0;
          div_q <= '0;
        end
      end else begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (fall_ev_o) begin
          sck_q  <= 1'b0;
          mosi_q <= sh_q[DW-1];
          sh_q   <= {sh_q[DW-2:0], 1'b0};
        end
        if (rise_ev_o) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[DW-2:0], miso_i};
          bit_q <= bit_q + 1'b1;
          if (last_bit) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign sck_o    = sck_q;
  assign mosi_o   = mosi_q;
  assign active_o = act_q;
  assign done_o   = done_q;
  assign rx_o     = rx_q;

endmodule

// File: rtl/spi_irq_host.sv
module spi_irq_host
  import spi_irq_host_pkg::*;
#(
  parameter longint CLK_HZ      = 100_000_000,
  parameter longint SCK_MAX_HZ  = 3_000_000,
  parameter int     CS_SETUP_NS = 100,
  parameter int     CS_HOLD_NS  = 17,
  parameter int     LEN_W       = 8,
  parameter int     TO_W        = 16,
  parameter int     SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_n_i,
  output logic              wake_o,
  output logic              cs_n_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [TO_W-1:0]   timeout_i,
  input  logic [7:0]        tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [7:0]        rx_data_o,
  output logic              rx_valid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int HALF_CYC  = sck_half_cycles(CLK_HZ, SCK_MAX_HZ);
  localparam int SETUP_CYC = ns_to_cycles(longint'(CS_SETUP_NS), CLK_HZ);
  localparam int HOLD_CYC  = ns_to_cycles(longint'(CS_HOLD_NS), CLK_HZ);
  localparam int CNT_W     = max3(TO_W, $clog2(SETUP_CYC + 1), $clog2(HOLD_CYC + 1)) + 1;
  localparam int REM_W     = LEN_W + 1;

  host_st_t         state_q, state_nxt;
  logic [CNT_W-1:0] cnt;
  logic [REM_W-1:0] rem_q;
  logic             err_q;
  logic             done_q;

  // named internal events
  logic irq_seen;
  logic setup_ev;
  logic hold_ev;
  logic timeout_ev;
  logic byte_go;
  logic byte_end;
  logic last_byte;
  logic frame_open;
  logic leave_idle;
  logic xfer_end_ev;
  logic eng_active;
  logic eng_fall;
  logic eng_rise;
  logic [7:0] eng_rx;
  logic [15:0] half_cyc_w;

  assign half_cyc_w = 16'(HALF_CYC);

  spi_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_n_i  (irq_n_i),
    .asserted_o (irq_seen)
  );

  spi_irq_cnt #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (state_nxt != state_q),
    .q_o   (cnt)
  );

  spi_byte_engine #(.HALF(HALF_CYC), .DW(BYTE_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (byte_go),
    .tx_i      (tx_data_i),
    .miso_i    (miso_i),
    .sck_o     (sck_o),
    .mosi_o    (mosi_o),
    .active_o  (eng_active),
    .done_o    (byte_end),
    .rx_o      (eng_rx),
    .fall_ev_o (eng_fall),
    .rise_ev_o (eng_rise)
  );

  assign setup_ev   = (state_q == ST_CSSU) && (cnt == CNT_W'(SETUP_CYC - 1));
  assign hold_ev    = (state_q == ST_HOLD) && (cnt == CNT_W'(HOLD_CYC - 1));
  assign timeout_ev = (state_q == ST_WAKE) && !irq_seen && (cnt == CNT_W'(timeout_i));
  assign byte_go    = (state_q == ST_LOAD) && tx_valid_i;
  assign last_byte  = (rem_q == REM_W'(1));
  assign frame_open = (state_q inside {ST_IDLE, ST_WAKE}) && (state_nxt == ST_CSSU);
  assign leave_idle = (state_q == ST_IDLE) && (state_nxt != ST_IDLE);
  assign xfer_end_ev = hold_ev;

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (irq_seen)     state_nxt = ST_CSSU;
        else if (start_i) state_nxt = ST_WAKE;
      end
      ST_WAKE: begin
        if (irq_seen)        state_nxt = ST_CSSU;
        else if (timeout_ev) state_nxt = ST_IDLE;
      end
      ST_CSSU:  if (setup_ev) state_nxt = ST_LOAD;
      ST_LOAD:  if (byte_go)  state_nxt = ST_SHIFT;
      ST_SHIFT: if (byte_end) state_nxt = last_byte ? ST_HOLD : ST_LOAD;
      ST_HOLD:  if (hold_ev)  state_nxt = ST_IDLE;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      done_q  <= xfer_end_ev;
      if (frame_open)
        rem_q <= {1'b0, len_i} + REM_W'(1);
      else if (byte_end && (state_q == ST_SHIFT))
        rem_q <= rem_q - REM_W'(1);
      if (timeout_ev)      err_q <= 1'b1;
      else if (leave_idle) err_q <= 1'b0;
    end
  end

  assign wake_o     = (state_q == ST_WAKE);
  assign cs_n_o     = !(state_q inside {ST_CSSU, ST_LOAD, ST_SHIFT, ST_HOLD});
  assign tx_ready_o = (state_q == ST_LOAD);
  assign rx_data_o  = eng_rx;
  assign rx_valid_o = byte_end;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;

endmodule

// File: rtl/spi_irq_host_chk.sv
module spi_irq_host_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        sck,
  input logic        wake,
  input logic        done,
  input logic        rx_valid,
  input logic        err,
  input logic        tx_ready,
  input logic [15:0] half_cyc
);

  logic [15:0] low_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   low_len <= '0;
    else if (!sck) low_len <= low_len + 16'd1;
    else          low_len <= '0;
  end

  assert_sck_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sck);

  assert_wake_outside_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> cs_n);

  assert_fall_inside_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> $past(!cs_n));

  assert_done_at_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $past(!cs_n)));

  assert_rx_inside_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !cs_n);

  assert_err_without_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (cs_n && !wake));

  assert_low_phase_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> (low_len == half_cyc));

  assert_stall_clock_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!cs_n && sck));

endmodule

bind spi_irq_host spi_irq_host_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n_o),
  .sck      (sck_o),
  .wake     (wake_o),
  .done     (done_o),
  .rx_valid (rx_valid_o),
  .err      (err_o),
  .tx_ready (tx_ready_o),
  .half_cyc (half_cyc_w)
);

// File: tb/spi_irq_host_bench.sv
module spi_irq_host_bench;

  localparam longint CLK_HZ = 100_000_000;
  localparam longint SCK_HZ = 3_000_000;

  logic clk = 1'b0;
  logic rst_n;
  logic irq_n = 1'b1;
  logic wake_o, cs_n_o, sck_o, mosi_o;
  logic miso_i = 1'b0;
  logic start_i;
  logic [7:0] len_i;
  logic [15:0] timeout_i;
  logic [7:0] tx_data_i = 8'h00;
  logic tx_valid_i = 1'b0;
  logic tx_ready_o;
  logic [7:0] rx_data_o;
  logic rx_valid_o, busy_o, done_o, err_o;

  always #5 clk = ~clk;

  spi_irq_host u_spi_irq_host (
    .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n), .wake_o(wake_o), .cs_n_o(cs_n_o),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .start_i(start_i), .len_i(len_i),
    .timeout_i(timeout_i), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  // expected timing restated from the requirements in real time units
  int half_exp, setup_exp, hold_exp;
  initial begin
    real cyc_ns;
    cyc_ns = 1.0e9 / real'(CLK_HZ);
    half_exp = 1;
    while (real'(half_exp) * cyc_ns < 1.0e9 / (2.0 * real'(SCK_HZ))) half_exp++;
    setup_exp = 1;
    while (real'(setup_exp) * cyc_ns < 100.0) setup_exp++;
    hold_exp = 1;
    while (real'(hold_exp) * cyc_ns < 17.0) hold_exp++;
  end

  // scoreboard queues
  logic [7:0] tx_src_q[$];
  logic [7:0] exp_mosi_q[$];
  logic [7:0] per_resp_q[$];
  logic [7:0] exp_rx_q[$];

  int tm = 0, bm = 0, tmon = 0, bmon = 0, tper = 0, bper = 0, wd_bad = 0;

  function automatic bit ok(bit c, string req, int act, int exp);
    if (!c) $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    return c;
  endfunction

  task automatic push_pair(logic [7:0] tx, logic [7:0] resp, bit feed);
    if (feed) tx_src_q.push_back(tx);
    exp_mosi_q.push_back(tx);
    per_resp_q.push_back(resp);
    exp_rx_q.push_back(resp);
  endtask

  // transmit feeder: handshake fires at the edge after ready&valid seen
  bit prev_rv = 1'b0;
  always @(negedge clk) begin
    if (prev_rv && tx_src_q.size() > 0) void'(tx_src_q.pop_front());
    tx_valid_i = (tx_src_q.size() > 0);
    tx_data_i  = (tx_src_q.size() > 0) ? tx_src_q[0] : 8'h00;
    prev_rv    = tx_valid_i && tx_ready_o;
  end

  // sensor interrupt and wake model
  int req_cnt = 0, srv_cnt = 0, wcnt = 0;
  bit respond = 1'b1;
  always @(negedge clk) begin
    if (cs_n_o === 1'b0) begin
      irq_n = 1'b1;
    end else if (req_cnt != srv_cnt) begin
      irq_n   = 1'b0;
      srv_cnt = req_cnt;
    end else if (wake_o === 1'b1 && respond) begin
      wcnt++;
      if (wcnt >= 7) irq_n = 1'b0;
    end
    if (wake_o !== 1'b1) wcnt = 0;
  end

  // sensor shift model, mode 3
  int pbit = 0;
  logic [7:0] pcur = 8'h00, prx = 8'h00;
  always @(sck_o) begin
    if (cs_n_o === 1'b0) begin
      if (sck_o === 1'b0) begin
        if (pbit == 0) pcur = (per_resp_q.size() > 0) ? per_resp_q.pop_front() : 8'h00;
        miso_i = pcur[7];
        pcur   = {pcur[6:0], 1'b0};
      end else if (sck_o === 1'b1) begin
        prx = {prx[6:0], mosi_o};
        pbit++;
        if (pbit == 8) begin
          pbit = 0;
          tper++;
          if (exp_mosi_q.size() == 0) begin
            $display("FAIL R6 unexpected mosi byte actual=%0h expected=none", prx);
            bper++;
          end else begin
            logic [7:0] e;
            e = exp_mosi_q.pop_front();
            if (!ok(prx == e, "R6 mosi byte msb first", prx, e)) bper++;
          end
        end
      end
    end
  end

  // monitor: receive scoreboard and timing measurements
  bit cs_prev = 1'b1, sck_prev = 1'b1, wake_prev = 1'b0, first_fall = 1'b0;
  int cs_cnt = 0, lowrun = 0, since_rise = 0, wrun = 0, last_wake = 0;
  int falls = 0, wake_rises = 0, dones = 0;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (rx_valid_o) begin
        tmon++;
        if (exp_rx_q.size() == 0) begin
          $display("FAIL R10 extra rx byte actual=%0h expected=none", rx_data_o);
          bmon++;
        end else begin
          logic [7:0] e;
          e = exp_rx_q.pop_front();
          if (!ok(rx_data_o == e, "R6 R10 rx byte", rx_data_o, e)) bmon++;
        end
      end
      if (cs_prev && !cs_n_o) begin
        falls++; cs_cnt = 0; first_fall = 1'b0; since_rise = 0;
      end
      if (!cs_n_o) cs_cnt++;
      if (sck_prev && !sck_o) begin
        if (!first_fall) begin
          first_fall = 1'b1;
          tmon++;
          if (!ok(cs_cnt > setup_exp, "R8 cs setup cycles", cs_cnt - 1, setup_exp)) bmon++;
        end
      end
      if (!sck_o) lowrun++;
      if (!sck_prev && sck_o) begin
        tmon++;
        if (!ok(lowrun == half_exp, "R7 sck low phase", lowrun, half_exp)) bmon++;
        lowrun = 0;
        since_rise = 0;
      end
      if (!cs_n_o && sck_o) since_rise++;
      if (!cs_prev && cs_n_o) begin
        tmon++;
        if (!ok(done_o == 1'b1, "R10 done at cs release", done_o, 1)) bmon++;
        tmon++;
        if (!ok(since_rise >= hold_exp, "R11 cs hold cycles", since_rise, hold_exp)) bmon++;
      end
      if (wake_o && !wake_prev) wake_rises++;
      if (wake_o) wrun++;
      if (!wake_o && wake_prev) begin
        last_wake = wrun; wrun = 0;
        tmon++;
        if (!ok(cs_n_o == 1'b0 || err_o == 1'b1, "R3 wake ends with cs low", cs_n_o, 0)) bmon++;
      end
      if (done_o) dones++;
      cs_prev = cs_n_o; sck_prev = sck_o; wake_prev = wake_o;
    end
  end

  task automatic start_pulse();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int d0;
    d0 = dones;
    while (dones == d0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    int tot, bad;
    tot = tm + tmon + tper;
    bad = bm + bmon + bper + wd_bad;
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=hang expected=finish");
    wd_bad = 1;
    tm++;
    finish_run();
  end

  initial begin
    int w0, f0;
    rst_n = 1'b0; start_i = 1'b0; len_i = 8'd0; timeout_i = 16'd200;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    tm++; if (!ok(cs_n_o == 1'b1, "R1 cs_n", cs_n_o, 1)) bm++;
    tm++; if (!ok(sck_o == 1'b1, "R1 sck", sck_o, 1)) bm++;
    tm++; if (!ok({wake_o, busy_o, done_o, err_o, tx_ready_o} == 5'b0, "R1 flags",
                  {wake_o, busy_o, done_o, err_o, tx_ready_o}, 0)) bm++;

    // R2 interrupt-started frame of three bytes, no wake
    push_pair(8'hA5, 8'h5A, 1); push_pair(8'h3C, 8'hC3, 1); push_pair(8'hF0, 8'h0F, 1);
    len_i = 8'd2;
    w0 = wake_rises;
    req_cnt++;
    wait_done();
    tm++; if (!ok(wake_rises == w0, "R2 no wake on interrupt", wake_rises - w0, 0)) bm++;
    tm++; if (!ok(exp_rx_q.size() == 0, "R10 three bytes received", exp_rx_q.size(), 0)) bm++;

    // R3 host request wakes the sensor first
    push_pair(8'h81, 8'h7E, 1);
    len_i = 8'd0;
    w0 = wake_rises;
    start_pulse();
    wait_done();
    tm++; if (!ok(wake_rises == w0 + 1, "R3 one wake pulse", wake_rises - w0, 1)) bm++;
    tm++; if (!ok(last_wake >= 7 && last_wake <= 12, "R3 wake length", last_wake, 10)) bm++;
    tm++; if (!ok(err_o == 1'b0, "R5 no error after answer", err_o, 0)) bm++;

    // R4 no answer: timeout
    respond = 1'b0;
    timeout_i = 16'd20;
    f0 = falls;
    start_pulse();
    while (busy_o) @(negedge clk);
    @(negedge clk);
    tm++; if (!ok(last_wake == 21, "R4 wake cycles", last_wake, 21)) bm++;
    tm++; if (!ok(err_o == 1'b1, "R4 err set", err_o, 1)) bm++;
    tm++; if (!ok(falls == f0, "R4 no frame opened", falls - f0, 0)) bm++;
    repeat (10) @(negedge clk);
    tm++; if (!ok(err_o == 1'b1, "R5 err sticky", err_o, 1)) bm++;
    respond = 1'b1;
    timeout_i = 16'd200;

    // R9 stall between bytes; R5 error clears on new frame
    push_pair(8'h00, 8'hFF, 1);
    push_pair(8'hFF, 8'h00, 0);
    len_i = 8'd1;
    start_pulse();
    @(negedge clk);
    tm++; if (!ok(err_o == 1'b0, "R5 err cleared on leaving idle", err_o, 0)) bm++;
    while (!(tx_ready_o && exp_rx_q.size() == 1)) @(negedge clk);
    repeat (40) @(negedge clk);
    tm++; if (!ok({cs_n_o, sck_o, tx_ready_o} == 3'b011, "R9 stalled link",
                  {cs_n_o, sck_o, tx_ready_o}, 3)) bm++;
    tm++; if (!ok(exp_rx_q.size() == 1, "R9 no byte during stall", exp_rx_q.size(), 1)) bm++;
    tx_src_q.push_back(8'hFF);
    wait_done();
    tm++; if (!ok(exp_rx_q.size() == 0, "R9 second byte after release", exp_rx_q.size(), 0)) bm++;

    // R6 R10 four bytes with mixed bit patterns, interrupt-started
    push_pair(8'h01, 8'hAA, 1); push_pair(8'h80, 8'h55, 1);
    push_pair(8'h55, 8'h80, 1); push_pair(8'hAA, 8'h01, 1);
    len_i = 8'd3;
    req_cnt++;
    wait_done();
    repeat (5) @(negedge clk);
    tm++; if (!ok(exp_rx_q.size() == 0 && exp_mosi_q.size() == 0, "R10 all bytes exchanged",
                  exp_rx_q.size() + exp_mosi_q.size(), 0)) bm++;
    tm++; if (!ok(dones == 4, "R10 done pulses", dones, 4)) bm++;
    tm++; if (!ok(cs_n_o == 1'b1 && busy_o == 1'b0, "R10 idle after frames", busy_o, 0)) bm++;
    finish_run();
  end

endmodule